// File: doc/BRIEF.md
# Random Byte Register Peripheral

This block is a small register-mapped source of random bytes, handed out one at a time over a simple synchronous bus. Software writes an enable bit and a run-mode code. While both are set, the block captures a byte from an internal 32-bit pseudo-random shift register and raises a valid flag. Software polls the status register for the flag, then reads the data register. That read returns the byte, clears the flag and zeroes the stored byte. One cycle later a fresh byte is captured.

A bus read returns its data combinationally in the same cycle as the request. Writes take effect at the next clock edge. A write to the read-only data register is rejected, and so is any access to an offset that is not decoded. Both raise a one-cycle error output during the offending request.

Top module: `rand_byte_periph`

## Requirements
- R1: After reset the control byte, the mode byte and the stored data byte are all 0x00, so reads of offsets 0x000, 0x004 and 0x008 return 0x00.
- R2: Offset 0x000 is control/status, 0x004 is data and 0x008 is mode, matched on all 12 address bits. Read data appears in the same cycle as a read request. rdata is 0x00 whenever no read is requested.
- R3: In the control byte, bit 0 is enable, bit 1 is the valid flag, bits 5:2 are a stored prescale field and bits 7:6 are stored as well. A write updates every bit except bit 1, which software cannot change.
- R4: The generator is active only when enable is 1 and the mode byte equals 0x02. Any other mode value keeps it idle.
- R5: While the generator is idle, bit 1 of the control byte reads as 0.
- R6: When the generator is active with the valid flag low at a clock edge, the flag reads 1 from the next cycle on, and the data byte then holds the random source's low byte as it was at that edge.
- R7: A data read while active and valid returns the stored byte. From the next cycle the valid flag is 0 and the stored byte is 0x00.
- R8: A data read while idle or not valid returns 0x00 and changes no state.
- R9: The random source is a 32-bit right-shifting Galois register with feedback mask 0x80200003 and seed 0xACE12468. It loads the seed during reset and steps on every clock edge after reset.
- R10: A write to offset 0x004 changes nothing and drives err high in the same cycle.
- R11: An access to any offset other than 0x000, 0x004 or 0x008 reads 0x00, changes nothing and drives err high in the same cycle.
- R12: The mode byte stores all 8 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the request cycle |
| err | output | 1 | Error, high in the cycle of a rejected access |

## Verification
rdata and err are due in the request cycle itself. The bench drives each request just after a falling edge and compares these outputs one time unit later, before the next rising edge. Register writes, flag changes and byte captures land at the next rising edge. A consuming read therefore shows a cleared flag on the following status read, and a new byte one cycle after that. The bench holds a reference model that steps on the same rising edge as the design. Every observation is compared with that model's state, so each result is checked in exactly the cycle it is due.

// File: rtl/rbp_pkg.sv
// Package: shared constants and types for the random byte peripheral.
// Assumes byte-wide registers and a 12-bit byte offset.
package rbp_pkg;
    localparam int OFF_CTL  = 'h000;
    localparam int OFF_DATA = 'h004;
    localparam int OFF_MODE = 'h008;

    localparam int EN_BIT  = 0;
    localparam int VLD_BIT = 1;

    localparam logic [7:0] MODE_RUN = 8'h02;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_MODE = 2'd3
    } rbp_sel_e;
endpackage

// File: rtl/rbp_lfsr.sv
// Module: right-shifting Galois pseudo-random register.
// It steps on every clock out of reset and loads SEED during reset.
// Assumes SEED is nonzero and MASK describes a maximal-length polynomial.
module rbp_lfsr #(
    parameter int          WIDTH = 32,
    parameter int          OUT_W = 8,
    parameter logic [WIDTH-1:0] MASK = 32'h8020_0003,
    parameter logic [WIDTH-1:0] SEED = 32'hACE1_2468
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    // Next state: shift right, fold the mask in when a one leaves the register.
    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) state_d = state_d ^ MASK;
    end

    // State register: seeded in reset, stepping every cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/rbp_decode.sv
// Module: bus address decode and error detection.
// Exact match on the full offset. Writes to data and unknown offsets are errors.
module rbp_decode
    import rbp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output rbp_sel_e          sel,
    output logic              rd_en,
    output logic              wr_en,
    output logic              err
);
    // Target select from the offset.
    always_comb begin
        if (addr == ADDR_W'(OFF_CTL))       sel = SEL_CTL;
        else if (addr == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
        else if (addr == ADDR_W'(OFF_MODE)) sel = SEL_MODE;
        else                                sel = SEL_NONE;
    end

    // Qualified strobes and the error flag.
    always_comb begin
        rd_en = req && !we && (sel != SEL_NONE);
        wr_en = req && we && (sel == SEL_CTL || sel == SEL_MODE);
        err   = req && ((sel == SEL_NONE) || (we && sel == SEL_DATA));
    end
endmodule

// File: rtl/rbp_regs.sv
// Module: control, mode, valid flag and data byte storage.
// The valid flag is hardware-owned. Read views are gated by the active state.
// Assumes strobes are already qualified by the decoder.
module rbp_regs
    import rbp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rbp_sel_e          sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rand_byte,
    output logic [DATA_W-1:0] ctl_view,
    output logic [DATA_W-1:0] data_view,
    output logic [DATA_W-1:0] mode_q,
    output logic              active,
    output logic              valid_q,
    output logic [DATA_W-1:0] data_q
);
    logic [DATA_W-1:0] ctl_q;
    logic              consume;

    // Active qualification and the consuming-read strobe.
    always_comb begin
        active  = ctl_q[EN_BIT] && (mode_q == DATA_W'(MODE_RUN));
        consume = rd_en && (sel == SEL_DATA) && active && valid_q;
    end

    // Control byte: software bits only, the flag position is held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (wr_en && sel == SEL_CTL) begin
            ctl_q          <= wdata;
            ctl_q[VLD_BIT] <= 1'b0;
        end
    end

    // Mode byte: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode_q <= '0;
        else if (wr_en && sel == SEL_MODE) mode_q <= wdata;
    end

    // Valid flag: cleared when idle or consumed, set when a byte is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= 1'b0;
        else if (!active) valid_q <= 1'b0;
        else if (consume) valid_q <= 1'b0;
        else if (!valid_q) valid_q <= 1'b1;
    end

    // Data byte: zeroed on consume, captured when active and empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                  data_q <= '0;
        else if (consume)            data_q <= '0;
        else if (active && !valid_q) data_q <= rand_byte;
    end

    // Read views as software sees them.
    always_comb begin
        ctl_view          = ctl_q;
        ctl_view[VLD_BIT] = valid_q && active;
        data_view         = (active && valid_q) ? data_q : '0;
    end
endmodule

// File: rtl/rand_byte_periph.sv
// Module: top of the random byte peripheral.
// Combines decode, storage and the pseudo-random source, and muxes read data.
// Assumes a single-cycle bus: read data and err are valid in the request cycle.
module rand_byte_periph
    import rbp_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 8,
    parameter int          LFSR_W  = 32,
    parameter logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    rbp_sel_e          sel;
    logic              rd_en;
    logic              wr_en;
    logic [DATA_W-1:0] rand_byte;
    logic [DATA_W-1:0] ctl_view;
    logic [DATA_W-1:0] data_view;
    logic [DATA_W-1:0] mode_q;
    logic              active;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    rbp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req   (req),
        .we    (we),
        .addr  (addr),
        .sel   (sel),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .err   (err)
    );

    rbp_lfsr #(
        .WIDTH (LFSR_W),
        .OUT_W (DATA_W),
        .MASK  (LFSR_MASK),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rand_byte)
    );

    rbp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rand_byte (rand_byte),
        .ctl_view  (ctl_view),
        .data_view (data_view),
        .mode_q    (mode_q),
        .active    (active),
        .valid_q   (valid_q),
        .data_q    (data_q)
    );

    // Read mux: zero unless a decoded read is requested.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CTL:  rdata = ctl_view;
                SEL_DATA: rdata = data_view;
                SEL_MODE: rdata = mode_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rbp_checker.sv
// Module: temporal checks for the random byte peripheral, bound to the top.
// It observes ports and the flag, active and data state.
module rbp_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              err,
    input logic              active,
    input logic              valid_q,
    input logic [DATA_W-1:0] data_q
);
    logic known;
    logic data_rd;
    logic status_rd;

    // Classify the current access.
    always_comb begin
        known     = (addr == ADDR_W'(0)) || (addr == ADDR_W'(4)) || (addr == ADDR_W'(8));
        data_rd   = req && !we && (addr == ADDR_W'(4));
        status_rd = req && !we && (addr == ADDR_W'(0));
    end

    a_r5_idle_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !active) |-> (rdata[1] == 1'b0));

    a_r6_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !valid_q) |=> valid_q);

    a_r7_consume_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && active && valid_q) |=> (!valid_q && data_q == '0));

    a_r7_consume_returns_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && active && valid_q) |-> (rdata == data_q));

    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(active && valid_q)) |-> (rdata == '0));

    a_r10_data_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == ADDR_W'(4)) |-> err);

    a_r11_unknown_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !known) |-> (err && rdata == '0));

    a_r2_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req) |-> (rdata == '0 && !err));
endmodule

bind rand_byte_periph rbp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .rdata   (rdata),
    .err     (err),
    .active  (active),
    .valid_q (valid_q),
    .data_q  (data_q)
);

// File: tb/rand_byte_periph_bench.sv
`timescale 1ns/1ps
// Bench: reference model stepped on the rising edge. Each request is driven
// after a falling edge and compared one time unit later.
module rand_byte_periph_bench;
    localparam logic [31:0] MASK = 32'h8020_0003;
    localparam logic [31:0] SEED = 32'hACE1_2468;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [7:0]  m_ctl = '0;
    logic [7:0]  m_mode = '0;
    logic [7:0]  m_data = '0;
    logic        m_valid = 1'b0;
    logic [31:0] m_lfsr = SEED;

    rand_byte_periph u_rand_byte_periph (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        logic [31:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ MASK;
        return n;
    endfunction

    function automatic logic m_active();
        return m_ctl[0] && (m_mode == 8'h02);
    endfunction

    function automatic logic exp_err(input logic r, input logic w, input logic [11:0] a);
        return r && ((a != 12'h000 && a != 12'h004 && a != 12'h008) || (w && a == 12'h004));
    endfunction

    function automatic logic [7:0] exp_rdata(input logic r, input logic w, input logic [11:0] a);
        logic [7:0] v;
        v = 8'h00;
        if (r && !w) begin
            if (a == 12'h000)      begin v = m_ctl; v[1] = m_valid && m_active(); end
            else if (a == 12'h004) v = (m_active() && m_valid) ? m_data : 8'h00;
            else if (a == 12'h008) v = m_mode;
        end
        return v;
    endfunction

    // Reference model update at the same edge the design registers.
    always @(posedge clk) begin
        logic consume;
        if (!rst_n) begin
            m_ctl = '0; m_mode = '0; m_data = '0; m_valid = 1'b0; m_lfsr = SEED;
        end else begin
            consume = req && !we && addr == 12'h004 && m_active() && m_valid;
            if (consume)                     m_data = 8'h00;
            else if (m_active() && !m_valid) m_data = m_lfsr[7:0];
            m_valid = m_active() && (m_valid ? !consume : 1'b1);
            if (req && we && addr == 12'h000) m_ctl = wdata & 8'hFD;
            if (req && we && addr == 12'h008) m_mode = wdata;
            m_lfsr = lfsr_step(m_lfsr);
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, then compare rdata and err against the model.
    task automatic bus(input logic r, input logic w, input logic [11:0] a,
                       input logic [7:0] d, input string tag);
        @(negedge clk);
        req = r; we = w; addr = a; wdata = d;
        #1;
        check({tag, " rdata"}, rdata, exp_rdata(r, w, a));
        check({tag, " err"}, {7'b0, err}, {7'b0, exp_err(r, w, a)});
    endtask

    function automatic string tag_for(input logic w, input logic [11:0] a);
        if (a == 12'h000) return w ? "R3" : "R5";
        if (a == 12'h004) return w ? "R10" : "R7";
        if (a == 12'h008) return "R12";
        return "R11";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        bus(1, 0, 12'h000, 0, "R1 ctl");
        bus(1, 0, 12'h004, 0, "R1 data");
        bus(1, 0, 12'h008, 0, "R1 mode");
        bus(0, 0, 12'h000, 0, "R2 no request");
        // R4: enable with wrong mode stays idle
        bus(1, 1, 12'h000, 8'h3F, "R3 ctl write");
        bus(1, 0, 12'h000, 0, "R3 flag not writable");
        bus(1, 1, 12'h008, 8'h03, "R12 mode write");
        bus(1, 0, 12'h000, 0, "R4 wrong mode idle");
        bus(1, 0, 12'h004, 0, "R8 idle data read");
        // R6/R9: go active, byte captured one cycle later
        bus(1, 1, 12'h008, 8'h02, "R4 run mode");
        bus(1, 0, 12'h000, 0, "R6 flag low first");
        bus(1, 0, 12'h000, 0, "R6 flag set");
        bus(1, 0, 12'h004, 0, "R9 captured byte");
        bus(1, 0, 12'h000, 0, "R7 flag cleared");
        bus(1, 0, 12'h000, 0, "R6 recapture");
        bus(1, 1, 12'h004, 8'hAA, "R10 data write");
        bus(1, 0, 12'h004, 0, "R10 data intact");
        bus(1, 1, 12'h010, 8'h00, "R11 unknown write");
        bus(1, 0, 12'h001, 0, "R11 unaligned read");
        bus(1, 0, 12'h008, 0, "R11 mode intact");
        // R5: disable drops the flag
        bus(1, 1, 12'h000, 8'hC4, "R3 disable");
        bus(1, 0, 12'h000, 0, "R5 flag masked");
        bus(1, 0, 12'h004, 0, "R8 disabled read");
        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            logic        w;
            int          k;
            k = $urandom_range(0, 9);
            a = (k < 4) ? 12'h000 : (k < 7) ? 12'h004 : (k < 9) ? 12'h008 : 12'($urandom);
            w = ($urandom_range(0, 4) == 0);
            b = 8'($urandom);
            if (w && a == 12'h000 && $urandom_range(0, 3) != 0) b[0] = 1'b1;
            if (w && a == 12'h008 && $urandom_range(0, 3) != 0) b = 8'h02;
            bus($urandom_range(0, 5) != 0, w, a, b, tag_for(w, a));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule